// File: doc/BRIEF.md
# Raster Line and Frame Interrupt Generator

This block follows the beam position of a video raster clocked at one pixel per cycle. It raises timed interrupt requests from that position. A horizontal counter runs across every pixel of a line, including blanking. A vertical counter advances once per line. Position (0,0) is the top-left pixel of the active picture.

Software can shift the vertical coordinate seen by the line comparator and by the readback by a programmable offset. The horizontal origin cannot be moved.

Two request sources exist:

- **Frame request.** It fires once per frame at a fixed point in vertical blank. This point is counted on the unshifted line count, at pixel 0 or, in a delayed variant, at pixel 1.
- **Line request.** It fires for a programmed target line. It fires one line early, on the pixel just after the last active pixel of that earlier line. This leaves the whole horizontal blank for work before the target line is drawn.

Each source has its own enable and its own sticky status flag. A small write port holds the control, target, offset and status-clear registers.

Top module: `raster_irq_gen`

## Requirements
- R1: `hpos` is 0 in reset, then rises by one every clock and wraps from H_TOTAL-1 to 0.
- R2: The raw line count is 0 in reset and advances by one (modulo V_TOTAL) when `hpos` wraps. `vpos` equals (raw line + offset) modulo V_TOTAL.
- R3: `line_irq` is high for exactly one cycle, when line enable is set, `hpos` equals H_ACTIVE and `vpos` equals target-1.
- R4: A target of 0 matches on `vpos` = V_TOTAL-1, the last line of the frame.
- R5: `frame_irq` is high for exactly one cycle per frame, when frame enable is set and the raw line equals FRAME_LINE. The pixel is `hpos` = 0, or `hpos` = 1 when FRAME_LATE is 1. The offset has no effect on it.
- R6: Address 0 is control: bit 0 enables the frame request and bit 1 the line request. After reset, frame enable is 1 and line enable is 0. A disabled source produces no pulse and sets no status.
- R7: `irq_status` bit 0 (frame) and bit 1 (line) are set in the cycle after the matching pulse and stay set. Writing address 3 clears each bit whose data bit is 1. A set in the same cycle wins over the clear.
- R8: A register write is in effect from the next clock on. A match position that was already passed in the current frame does not fire again after the target changes.
- R9: Address 1 holds the target line and address 2 the offset, both 0 after reset. A write whose value is not below V_TOTAL is ignored and the register keeps its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 control, 1 target, 2 offset, 3 status clear) |
| wr_data | input | DATA_W | Write data |
| hpos | output | $clog2(H_TOTAL) | Current horizontal pixel position |
| vpos | output | $clog2(V_TOTAL) | Current vertical position including offset |
| frame_irq | output | 1 | One-cycle frame request pulse |
| line_irq | output | 1 | One-cycle line request pulse |
| irq_status | output | 2 | Sticky flags: bit 0 frame, bit 1 line |

## Verification
The in-RTL properties run on every cycle and cover the following:

- the single-step and wrap behaviour of the horizontal counter;
- the vertical count holding within a line and stepping at the line end;
- the one-cycle width of both pulses;
- the set, hold and clear rules of the status flags;
- the refusal of out-of-range target and offset writes.

Only the bench scenarios can show where in the frame each pulse lands. This includes the line request landing one line early at the end of the active area, the wrap of target 0 onto the last line, and the frame request ignoring the offset. The same holds for the absence of a second pulse after a retarget, and for the one-cycle latency of register writes.

// File: rtl/raster_irq_pkg.sv
package raster_irq_pkg;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_TARGET = 2'd1,
    REG_OFFSET = 2'd2,
    REG_STATUS = 2'd3
  } reg_addr_e;

  localparam int SRC_FRAME = 0;
  localparam int SRC_LINE  = 1;
  localparam int NUM_SRC   = 2;

endpackage

// File: rtl/raster_irq_regs.sv
module raster_irq_regs
  import raster_irq_pkg::*;
#(
  parameter int V_TOTAL = 312,
  parameter int DATA_W  = 16,
  localparam int VW     = $clog2(V_TOTAL)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic               frame_en,
  output logic               line_en,
  output logic [VW-1:0]      target,
  output logic [VW-1:0]      offset,
  output logic [NUM_SRC-1:0] clr_mask
);

  logic in_range;
  logic wr_ctrl, wr_tgt, wr_off, wr_stat;

  assign in_range = (wr_data < DATA_W'(V_TOTAL));
  assign wr_ctrl  = wr_en && (wr_addr == REG_CTRL);
  assign wr_tgt   = wr_en && (wr_addr == REG_TARGET) && in_range;
  assign wr_off   = wr_en && (wr_addr == REG_OFFSET) && in_range;
  assign wr_stat  = wr_en && (wr_addr == REG_STATUS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_en <= 1'b1;
      line_en  <= 1'b0;
    end else if (wr_ctrl) begin
      frame_en <= wr_data[SRC_FRAME];
      line_en  <= wr_data[SRC_LINE];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      target <= '0;
    else if (wr_tgt) target <= wr_data[VW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      offset <= '0;
    else if (wr_off) offset <= wr_data[VW-1:0];
  end

  assign clr_mask = wr_stat ? wr_data[NUM_SRC-1:0] : '0;

  AST_TARGET_RANGE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == REG_TARGET && wr_data >= DATA_W'(V_TOTAL)) |=> $stable(target)); // R9
  AST_OFFSET_RANGE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == REG_OFFSET && wr_data >= DATA_W'(V_TOTAL)) |=> $stable(offset)); // R9
  AST_TARGET_BELOW_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    target < VW'(V_TOTAL)); // R9

endmodule

// File: rtl/raster_hv_counter.sv
module raster_hv_counter #(
  parameter int H_TOTAL = 448,
  parameter int V_TOTAL = 312,
  localparam int HW     = $clog2(H_TOTAL),
  localparam int VW     = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [HW-1:0] h_cnt,
  output logic [VW-1:0] v_raw,
  output logic          line_end
);

  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);

  assign line_end = (h_cnt == H_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        h_cnt <= '0;
    else if (line_end) h_cnt <= '0;
    else               h_cnt <= h_cnt + HW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 v_raw <= '0;
    else if (line_end) begin
      if (v_raw == V_LAST)      v_raw <= '0;
      else                      v_raw <= v_raw + VW'(1);
    end
  end

  AST_H_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (h_cnt == H_LAST) |=> (h_cnt == '0)); // R1
  AST_H_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (h_cnt != H_LAST) |=> (h_cnt == $past(h_cnt) + HW'(1))); // R1
  AST_V_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (h_cnt != H_LAST) |=> $stable(v_raw)); // R2
  AST_V_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (h_cnt == H_LAST) |=> (v_raw != $past(v_raw))); // R2

endmodule

// File: rtl/raster_irq_match.sv
module raster_irq_match #(
  parameter int H_TOTAL    = 448,
  parameter int H_ACTIVE   = 256,
  parameter int V_TOTAL    = 312,
  parameter int FRAME_LINE = 248,
  parameter bit FRAME_LATE = 1'b0,
  localparam int HW        = $clog2(H_TOTAL),
  localparam int VW        = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] h_cnt,
  input  logic [VW-1:0] v_raw,
  input  logic [VW-1:0] offset,
  input  logic [VW-1:0] target,
  input  logic          frame_en,
  input  logic          line_en,
  output logic [VW-1:0] v_coord,
  output logic          frame_pulse,
  output logic          line_pulse
);

  localparam logic [HW-1:0] H_LINE_HIT  = HW'(H_ACTIVE);
  localparam logic [HW-1:0] H_FRAME_HIT = FRAME_LATE ? HW'(1) : HW'(0);
  localparam logic [VW-1:0] V_FRAME_HIT = VW'(FRAME_LINE);

  function automatic logic [VW-1:0] wrap_add(input logic [VW-1:0] a, input logic [VW-1:0] b);
    logic [VW:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= (VW+1)'(V_TOTAL)) s = s - (VW+1)'(V_TOTAL);
    return s[VW-1:0];
  endfunction

  function automatic logic [VW-1:0] line_before(input logic [VW-1:0] y);
    return (y == '0) ? VW'(V_TOTAL - 1) : (y - VW'(1));
  endfunction

  logic [VW-1:0] line_hit_row;

  assign v_coord      = wrap_add(v_raw, offset);
  assign line_hit_row = line_before(target);
  assign line_pulse   = line_en  && (h_cnt == H_LINE_HIT)  && (v_coord == line_hit_row);
  assign frame_pulse  = frame_en && (h_cnt == H_FRAME_HIT) && (v_raw == V_FRAME_HIT);

  AST_LINE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    line_pulse |=> !line_pulse); // R3
  AST_FRAME_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |=> !frame_pulse); // R5
  AST_VCOORD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    v_coord < VW'(V_TOTAL)); // R2

endmodule

// File: rtl/raster_irq_status.sv
module raster_irq_status #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags
);

  for (genvar k = 0; k < N; k++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flags[k] <= 1'b0;
      else if (set_i[k]) flags[k] <= 1'b1;
      else if (clr_i[k]) flags[k] <= 1'b0;
    end

    AST_STATUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[k] |=> flags[k]); // R7
    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[k] && !clr_i[k]) |=> flags[k]); // R7
    AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[k] && !set_i[k]) |=> !flags[k]); // R7
  end

endmodule

// File: rtl/raster_irq_gen.sv
module raster_irq_gen
  import raster_irq_pkg::*;
#(
  parameter int H_TOTAL    = 448,
  parameter int H_ACTIVE   = 256,
  parameter int V_TOTAL    = 312,
  parameter int FRAME_LINE = 248,
  parameter bit FRAME_LATE = 1'b0,
  parameter int DATA_W     = 16,
  localparam int HW        = $clog2(H_TOTAL),
  localparam int VW        = $clog2(V_TOTAL)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [HW-1:0]       hpos,
  output logic [VW-1:0]       vpos,
  output logic                frame_irq,
  output logic                line_irq,
  output logic [NUM_SRC-1:0]  irq_status
);

  logic               frame_en, line_en;
  logic [VW-1:0]      target, offset, v_raw;
  logic [NUM_SRC-1:0] clr_mask, set_mask;
  logic               line_end;

  raster_irq_regs #(.V_TOTAL(V_TOTAL), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .frame_en(frame_en), .line_en(line_en), .target(target), .offset(offset),
    .clr_mask(clr_mask)
  );

  raster_hv_counter #(.H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL)) u_cnt (
    .clk(clk), .rst_n(rst_n), .h_cnt(hpos), .v_raw(v_raw), .line_end(line_end)
  );

  raster_irq_match #(
    .H_TOTAL(H_TOTAL), .H_ACTIVE(H_ACTIVE), .V_TOTAL(V_TOTAL),
    .FRAME_LINE(FRAME_LINE), .FRAME_LATE(FRAME_LATE)
  ) u_match (
    .clk(clk), .rst_n(rst_n), .h_cnt(hpos), .v_raw(v_raw), .offset(offset),
    .target(target), .frame_en(frame_en), .line_en(line_en), .v_coord(vpos),
    .frame_pulse(frame_irq), .line_pulse(line_irq)
  );

  always_comb begin
    set_mask            = '0;
    set_mask[SRC_FRAME] = frame_irq;
    set_mask[SRC_LINE]  = line_irq;
  end

  raster_irq_status #(.N(NUM_SRC)) u_status (
    .clk(clk), .rst_n(rst_n), .set_i(set_mask), .clr_i(clr_mask), .flags(irq_status)
  );

  AST_NO_LINE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == REG_CTRL && !wr_data[SRC_LINE]) |=> !line_irq); // R6
  AST_NO_FRAME_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == REG_CTRL && !wr_data[SRC_FRAME]) |=> !frame_irq); // R6
  AST_LINE_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    line_irq |=> !line_end); // R3

endmodule

// File: tb/test_raster_irq_gen.sv
module test_raster_irq_gen;

  localparam int CLK_P = 10;
  localparam int HT = 12;
  localparam int HA = 8;
  localparam int VT = 10;
  localparam int FL = 7;
  localparam int FH = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [3:0]  hpos;
  logic [3:0]  vpos;
  logic        frame_irq, line_irq;
  logic [1:0]  irq_status;

  raster_irq_gen #(
    .H_TOTAL(HT), .H_ACTIVE(HA), .V_TOTAL(VT), .FRAME_LINE(FL), .FRAME_LATE(1'b1), .DATA_W(16)
  ) i_raster_irq_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hpos(hpos), .vpos(vpos), .frame_irq(frame_irq), .line_irq(line_irq),
    .irq_status(irq_status)
  );

  always #(CLK_P/2) clk = ~clk;

  int rc = 0;
  always @(posedge clk) begin
    if (!rst_n) rc <= 0;
    else        rc <= rc + 1;
  end

  int n_chk = 0, n_fail = 0;
  int nf, nl, bad_pos, bad_h, bad_v, cur_off, cur_tgt;

  typedef struct packed {
    logic [3:0] off;
    logic [3:0] tgt;
    logic [1:0] en;
    logic [1:0] exp_st;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{4'd0, 4'd3, 2'd3, 2'd3},
    '{4'd0, 4'd0, 2'd3, 2'd3},
    '{4'd4, 4'd2, 2'd2, 2'd2},
    '{4'd9, 4'd5, 2'd1, 2'd1},
    '{4'd3, 4'd0, 2'd0, 2'd0},
    '{4'd7, 4'd9, 2'd2, 2'd2}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int raw_line();
    return (rc / HT) % VT;
  endfunction

  task automatic run_frame();
    nf = 0; nl = 0; bad_pos = 0; bad_h = 0; bad_v = 0;
    for (int i = 0; i < HT*VT; i++) begin
      if (int'(hpos) != rc % HT) bad_h++;
      if (int'(vpos) != (raw_line() + cur_off) % VT) bad_v++;
      if (line_irq) begin
        nl++;
        if (int'(hpos) != HA || int'(vpos) != (cur_tgt + VT - 1) % VT ||
            raw_line() != (cur_tgt + VT - 1 - cur_off + VT) % VT) bad_pos++;
      end
      if (frame_irq) begin
        nf++;
        if (int'(hpos) != FH || raw_line() != FL) bad_pos++;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_P*50000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", rc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(hpos == 0 && vpos == 0, "R1 reset position", int'(hpos), 0);
    chk(irq_status == 0, "R7 reset status", int'(irq_status), 0);
    chk(!line_irq && !frame_irq, "R6 reset pulses", int'({line_irq, frame_irq}), 0);
    rst_n = 1'b1;
    cur_off = 0; cur_tgt = 0;

    run_frame();
    chk(nf == 1 && nl == 0, "R6 default enables", nf*10 + nl, 10);
    chk(bad_h == 0, "R1 horizontal count", bad_h, 0);
    chk(bad_pos == 0, "R5 frame position", bad_pos, 0);

    for (int r = 0; r < 6; r++) begin
      wr(2'd0, {14'd0, VEC[r].en});
      wr(2'd1, {12'd0, VEC[r].tgt});
      wr(2'd2, {12'd0, VEC[r].off});
      wr(2'd3, 16'd3);
      cur_off = int'(VEC[r].off); cur_tgt = int'(VEC[r].tgt);
      run_frame();
      chk(nf == int'(VEC[r].exp_st[0]), "R5 R6 frame pulse count", nf, int'(VEC[r].exp_st[0]));
      chk(nl == int'(VEC[r].exp_st[1]), "R3 R4 R6 line pulse count", nl, int'(VEC[r].exp_st[1]));
      chk(bad_pos == 0, "R3 R4 R5 pulse position", bad_pos, 0);
      chk(bad_v == 0, "R2 vertical coordinate with offset", bad_v, 0);
      chk(irq_status == VEC[r].exp_st, "R7 status after frame", int'(irq_status), int'(VEC[r].exp_st));
    end

    // R7 partial write-one-to-clear
    wr(2'd0, 16'd3); wr(2'd2, 16'd0); wr(2'd1, 16'd3);
    cur_off = 0; cur_tgt = 3;
    run_frame();
    chk(irq_status == 2'b11, "R7 both flags set", int'(irq_status), 3);
    wr(2'd3, 16'd1);
    chk(irq_status == 2'b10, "R7 clear frame only", int'(irq_status), 2);
    wr(2'd3, 16'd2);
    chk(irq_status == 2'b00, "R7 clear line", int'(irq_status), 0);

    // R7 set wins over clear in the same cycle
    wr(2'd0, 16'd1);
    while (!frame_irq) @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd3; wr_data = 16'd1;
    @(negedge clk);
    wr_en = 1'b0;
    chk(irq_status[0] == 1'b1, "R7 set wins", int'(irq_status[0]), 1);

    // R8 write effective on the next clock
    wr(2'd0, 16'd2); wr(2'd1, 16'd0);
    while (!(int'(hpos) == HA-1 && int'(vpos) == 4)) @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 16'd5;
    @(negedge clk);
    wr_en = 1'b0;
    chk(line_irq == 1'b1, "R8 next-cycle target", int'(line_irq), 1);

    // R8 passed match does not repeat
    wr(2'd1, 16'd6);
    while (!line_irq) @(negedge clk);
    @(negedge clk);
    wr(2'd1, 16'd3);
    nl = 0;
    while (!(vpos == 0 && hpos == 0)) begin
      if (line_irq) nl++;
      @(negedge clk);
    end
    chk(nl == 0, "R8 no refire after retarget", nl, 0);
    while (vpos != 3) begin
      if (line_irq) nl++;
      @(negedge clk);
    end
    chk(nl == 1, "R8 fires in next frame", nl, 1);

    // R9 out-of-range writes ignored
    wr(2'd2, 16'd3);
    wr(2'd2, 16'd12);
    chk(int'(vpos) == (raw_line() + 3) % VT, "R9 offset out of range ignored", int'(vpos), (raw_line() + 3) % VT);
    wr(2'd2, 16'd0);
    chk(int'(vpos) == raw_line(), "R9 offset zero accepted", int'(vpos), raw_line());

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule